// File: doc/BRIEF.md
# Sub-Range BCD Up/Down Counter

This block is a single decimal digit counter. It steps up or down on each rising clock edge while enabled. Two configuration inputs set the lowest and the highest value of the digit's cycle. Counting up from the highest value returns the digit to the lowest value, and counting down from the lowest value returns it to the highest value. A full 0-9 decade, a 0-5 tens-of-seconds digit or a 1-6 dice digit all come from the same logic.

The wrap is decided in the same cycle that the highest (or lowest) value is held in the register. The value one past the range therefore never reaches the output, not even for part of a cycle. The counter has a synchronous clear and a synchronous active-low parallel load. Clear wins over load, load wins over counting, and counting needs the enable.

Carry and borrow flags mark the cycle whose next edge wraps the digit. A second digit can use them directly as its count enable, in either direction.

Top module: `bcd_recycle_ctr`

## Requirements
- R1: While `rst_n` is low, `q` is 0 and `carry` and `borrow` are 0, without waiting for a clock edge.
- R2: `clr` high at a rising edge makes `q` 0, whatever `load_n`, `en`, `up` and `din` are.
- R3: With `clr` low and `load_n` low at a rising edge, `q` takes `din`, whether `en` is high or low.
- R4: With `clr` low, `load_n` high and `en` low, `q` keeps its value across the edge.
- R5: Counting up (`up`=1, `en`=1, no clear, no load) with `q` below the top value, `q` becomes `q`+1.
- R6: Counting up with `q` at or above the top value, `q` becomes `cfg_lo`. The value top+1 never appears: a 0..6 range gives 5,6,0 and a 1..6 range gives 6,1.
- R7: Counting down (`up`=0) with `q` above `cfg_lo`, `q` becomes `q`-1. With `q` at or below `cfg_lo`, `q` becomes the top value.
- R8: `carry` is 1 exactly in the cycles where a count-up step is enabled, `clr` is low, `load_n` is high and `q` is at or above the top value, so that the next edge wraps.
- R9: `borrow` is 1 exactly in the cycles where a count-down step is enabled, `clr` is low, `load_n` is high and `q` is at or below `cfg_lo`. `carry` and `borrow` are never high together.
- R10: The top value is `cfg_hi`, limited to 9. A `cfg_hi` above 9 behaves as 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to zero, active high, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en | input | 1 | Count enable |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | 4 | Parallel load value |
| cfg_lo | input | 4 | Lowest value of the cycle |
| cfg_hi | input | 4 | Highest value of the cycle (limited to 9) |
| q | output | 4 | Current BCD digit |
| carry | output | 1 | Up-wrap flag, usable as the next digit's enable |
| borrow | output | 1 | Down-wrap flag, usable as the next digit's enable |

## Verification
The assertions watch every cycle for these properties: the priority order of clear, load, hold and step; a single increment below the top; the landing values after a flagged carry or borrow; and carry and borrow never being high together. Some behaviour can only be shown by the bench's scenarios. This covers the exact wrap sequences for the 0..6, 1..6 and 0..9 ranges, recovery after a value outside the range has been loaded, the limit on a `cfg_hi` above 9, flags being masked by clear, and a reset in the middle of a cycle taking effect without a clock edge.

// File: rtl/bcd_recycle_ctr_pkg.sv
package bcd_recycle_ctr_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_STEP  = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } ctr_op_e;

   function automatic logic [3:0] clamp_top(input logic [3:0] v, input logic [3:0] lim);
      return (v > lim) ? lim : v;
   endfunction

endpackage

// File: rtl/bcd_recycle_ctr_ctrl.sv
module bcd_recycle_ctr_ctrl
   import bcd_recycle_ctr_pkg::*;
(
   input  logic    clr,
   input  logic    load_n,
   input  logic    en,
   output ctr_op_e op
);
   always_comb begin
      if (clr)          op = OP_CLEAR;
      else if (!load_n) op = OP_LOAD;
      else if (en)      op = OP_STEP;
      else              op = OP_HOLD;
   end
endmodule

// File: rtl/bcd_recycle_ctr_step.sv
module bcd_recycle_ctr_step #(
   parameter int DIGIT_W = 4
) (
   input  logic [DIGIT_W-1:0] q,
   input  logic [DIGIT_W-1:0] lo,
   input  logic [DIGIT_W-1:0] hi,
   input  logic               up,
   output logic               at_top,
   output logic               at_bot,
   output logic [DIGIT_W-1:0] nxt
);
   always_comb begin
      at_top = (q >= hi);
      at_bot = (q <= lo);
      if (up) nxt = at_top ? lo : DIGIT_W'(q + 1'b1);
      else    nxt = at_bot ? hi : DIGIT_W'(q - 1'b1);
   end
endmodule

// File: rtl/bcd_recycle_ctr.sv
module bcd_recycle_ctr
   import bcd_recycle_ctr_pkg::*;
#(
   parameter int DIGIT_W   = 4,
   parameter int DIGIT_MAX = 9,
   parameter bit REG_FLAGS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load_n,
   input  logic         en,
   input  logic         up,
   input  logic [3:0]   din,
   input  logic [3:0]   cfg_lo,
   input  logic [3:0]   cfg_hi,
   output logic [3:0]   q,
   output logic         carry,
   output logic         borrow
);
   localparam logic [3:0] MAX_V = 4'(DIGIT_MAX);

   if (DIGIT_W != 4) begin : g_bad_w
      $error("bcd_recycle_ctr: DIGIT_W must be 4");
   end
   if (DIGIT_MAX < 1 || DIGIT_MAX > 9) begin : g_bad_max
      $error("bcd_recycle_ctr: DIGIT_MAX must be 1..9");
   end

   ctr_op_e    op;
   logic [3:0] hi_eff;
   logic [3:0] nxt;
   logic       at_top, at_bot;
   logic       carry_c, borrow_c;

   assign hi_eff = clamp_top(cfg_hi, MAX_V);

   bcd_recycle_ctr_ctrl u_ctrl (
      .clr    (clr),
      .load_n (load_n),
      .en     (en),
      .op     (op)
   );

   bcd_recycle_ctr_step #(.DIGIT_W(DIGIT_W)) u_step (
      .q      (q),
      .lo     (cfg_lo),
      .hi     (hi_eff),
      .up     (up),
      .at_top (at_top),
      .at_bot (at_bot),
      .nxt    (nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else begin
         unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= din;
            OP_STEP:  q <= nxt;
            default:  q <= q;
         endcase
      end
   end

   assign carry_c  = (op == OP_STEP) &&  up && at_top;
   assign borrow_c = (op == OP_STEP) && !up && at_bot;

   if (REG_FLAGS) begin : g_flag_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            carry  <= 1'b0;
            borrow <= 1'b0;
         end else begin
            carry  <= carry_c;
            borrow <= borrow_c;
         end
      end
   end else begin : g_flag_comb
      assign carry  = carry_c & rst_n;
      assign borrow = borrow_c & rst_n;
   end
endmodule

// File: rtl/bcd_recycle_ctr_chk.sv
module bcd_recycle_ctr_chk #(
   parameter bit REG_FLAGS = 1'b0,
   parameter int DIGIT_MAX = 9
) (
   input logic       clk,
   input logic       rst_n,
   input logic       clr,
   input logic       load_n,
   input logic       en,
   input logic       up,
   input logic [3:0] din,
   input logic [3:0] cfg_lo,
   input logic [3:0] cfg_hi,
   input logic [3:0] q,
   input logic       carry,
   input logic       borrow
);
   logic [3:0] top_v;
   assign top_v = (cfg_hi > 4'(DIGIT_MAX)) ? 4'(DIGIT_MAX) : cfg_hi;

   p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> (q == 4'd0));

   p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == 4'd0));

   p_load_din_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_n) |=> (q == $past(din)));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && !en) |=> $stable(q));

   p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && en && up && (q < top_v)) |=> (q == $past(q) + 4'd1));

   if (!REG_FLAGS) begin : g_comb_flags
      p_carry_land_r6: assert property (@(posedge clk) disable iff (!rst_n)
         carry |=> (q == $past(cfg_lo)));
      p_borrow_land_r7: assert property (@(posedge clk) disable iff (!rst_n)
         borrow |=> (q == $past(top_v)));
      p_carry_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
         carry |-> (up && en && !clr && load_n));
   end

   p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(carry && borrow));
endmodule

bind bcd_recycle_ctr bcd_recycle_ctr_chk #(.REG_FLAGS(REG_FLAGS), .DIGIT_MAX(DIGIT_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .en(en), .up(up),
   .din(din), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .q(q), .carry(carry), .borrow(borrow)
);

// File: tb/bcd_recycle_ctr_bench.sv
module bcd_recycle_ctr_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       clr = 1'b0, load_n = 1'b1, en = 1'b0, up = 1'b1;
   logic [3:0] din = '0, cfg_lo = '0, cfg_hi = 4'd6;
   logic [3:0] q;
   logic       carry, borrow;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   bcd_recycle_ctr u_bcd_recycle_ctr (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .en(en), .up(up),
      .din(din), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .q(q), .carry(carry), .borrow(borrow)
   );

   // vector: clr load_n en up din lo hi | expected q after edge, carry, borrow before edge
   localparam int NV = 20;
   localparam logic [21:0] VEC [NV] = '{
      {1'b0,1'b0,1'b1,1'b1,4'd5,4'd0,4'd6, 4'd5,1'b0,1'b0}, // R3 load 5
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,4'd6, 4'd6,1'b0,1'b0}, // R5 5->6
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,4'd6, 4'd0,1'b1,1'b0}, // R6 R8 6->0
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,4'd6, 4'd1,1'b0,1'b0}, // R5 0->1
      {1'b0,1'b1,1'b0,1'b1,4'd8,4'd0,4'd6, 4'd1,1'b0,1'b0}, // R4 hold
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd1,4'd6, 4'd2,1'b0,1'b0}, // R5 1->2
      {1'b0,1'b0,1'b1,1'b1,4'd6,4'd1,4'd6, 4'd6,1'b0,1'b0}, // R3 load 6
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd1,4'd6, 4'd1,1'b1,1'b0}, // R6 6->1
      {1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,4'd6, 4'd6,1'b0,1'b1}, // R7 R9 1->6
      {1'b0,1'b1,1'b1,1'b0,4'd0,4'd1,4'd6, 4'd5,1'b0,1'b0}, // R7 6->5
      {1'b1,1'b0,1'b1,1'b0,4'd9,4'd1,4'd6, 4'd0,1'b0,1'b0}, // R2 clr over load
      {1'b0,1'b1,1'b1,1'b0,4'd0,4'd0,4'd9, 4'd9,1'b0,1'b1}, // R7 0->9
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,4'd9, 4'd0,1'b1,1'b0}, // R6 9->0
      {1'b0,1'b0,1'b0,1'b1,4'd3,4'd0,4'd9, 4'd3,1'b0,1'b0}, // R3 load with en low
      {1'b0,1'b0,1'b1,1'b1,4'd9,4'd1,4'd6, 4'd9,1'b0,1'b0}, // R3 load out of range
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd1,4'd6, 4'd1,1'b1,1'b0}, // R6 9>=6 -> 1
      {1'b0,1'b0,1'b1,1'b1,4'd6,4'd1,4'd6, 4'd6,1'b0,1'b0}, // R3 load 6
      {1'b1,1'b1,1'b1,1'b1,4'd0,4'd1,4'd6, 4'd0,1'b0,1'b0}, // R2 R8 clr masks carry
      {1'b0,1'b0,1'b1,1'b1,4'd9,4'd0,4'd15,4'd9,1'b0,1'b0}, // R3 load 9
      {1'b0,1'b1,1'b1,1'b1,4'd0,4'd0,4'd15,4'd0,1'b1,1'b0}  // R10 hi 15 acts as 9
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      int m;
      #2 rst_n = 1'b0;
      #1;
      chk("R1 reset q", q, 0);
      chk("R1 reset carry", carry, 0);
      chk("R1 reset borrow", borrow, 0);
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {clr, load_n, en, up, din, cfg_lo, cfg_hi} = VEC[i][21:6];
         #1;
         chk($sformatf("R8 carry vec%0d", i), carry, VEC[i][1]);
         chk($sformatf("R9 borrow vec%0d", i), borrow, VEC[i][0]);
         @(posedge clk); #1;
         chk($sformatf("R2-7 q vec%0d", i), q, VEC[i][5:2]);
      end

      // R6/R5 long run over 2..8
      @(negedge clk);
      clr = 0; load_n = 0; en = 1; up = 1; din = 4'd2; cfg_lo = 4'd2; cfg_hi = 4'd8;
      @(posedge clk); #1;
      chk("R3 load 2", q, 2);
      m = 2;
      @(negedge clk) load_n = 1;
      for (int k = 0; k < 16; k++) begin
         @(posedge clk); #1;
         m = (m >= 8) ? 2 : m + 1;
         chk("R6 range run", q, m);
         chk("R6 in range", int'(q >= 2 && q <= 8), 1);
      end

      // R1 asynchronous reset mid-cycle
      @(negedge clk);
      load_n = 0; din = 4'd7;
      @(posedge clk); #1;
      chk("R3 load 7", q, 7);
      load_n = 1;
      #2 rst_n = 1'b0;
      #1;
      chk("R1 async q", q, 0);
      @(posedge clk); #1;
      chk("R1 held in reset", q, 0);
      chk("R1 carry in reset", carry, 0);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R5 count after reset", q, 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule